// File: doc/BRIEF.md
# Amplifier Shutdown and Fault Controller

This block is the control state machine of a multi-channel switching audio amplifier. It takes an active-low shutdown request, an asynchronous active-low power-on reset, a short-circuit detect pulse, a DC-offset fault flag and a pair of over-temperature comparator results. It decides, every clock, whether the power stages switch or sit in high impedance, whether the amplifier is muted, and whether the active-low fault line is pulled down.

Each fault class has its own way of clearing. A DC fault stays until the next power-on reset. A short circuit is held until the shutdown request has been low for a programmable number of synchronised cycles. Over-temperature holds the outputs off until the hot indication is gone and the cool indication (the temperature below the trip point by the hysteresis amount) is present. Over-temperature never reports on the fault line. If the fault line is wired back into the shutdown request, a short circuit clears itself and the amplifier restarts without help.

The shutdown request may arrive from a pin that is not clocked. It passes through a synchroniser of `SYNC_STAGES` flops. The fault and temperature inputs come from logic that is already synchronous.

Top module: `amp_guard_ctrl`

## Requirements
- R1: While `rst_n` is low, the outputs are: every `ch_en_o` bit 0, `mute_o` 1, `fault_n_o` 1.
- R2: With no fault held, a low shutdown request gives all `ch_en_o` 0, `mute_o` 1 and `fault_n_o` 1. A high request with no fault or heat gives all `ch_en_o` 1 and `mute_o` 0.
- R3: A `sc_pulse_i` high at a rising edge while the synchronised request is high latches a short circuit. Two edges later, and from then on, the outputs are all `ch_en_o` 0, `mute_o` 0 and `fault_n_o` 0, whatever further pulses arrive or while the request stays high. After one edge the outputs are unchanged.
- R4: The short-circuit latch clears only after the synchronised request has been low for `CLR_MIN_LOW` consecutive cycles. A shorter low leaves the fault outputs in place.
- R5: A `dc_flag_i` high at a rising edge gives all `ch_en_o` 0 and `fault_n_o` 0 from two edges later. Any toggling of the shutdown request leaves this in place. Only `rst_n` low clears it.
- R6: `ot_hot_i` high gives all `ch_en_o` 0, `mute_o` 0 and `fault_n_o` 1 from two edges later. The outputs stay off until `ot_hot_i` is low and `ot_cool_i` is high, and then operation resumes with no other action.
- R7: Over-temperature alone never drives `fault_n_o` low.
- R8: The priority is DC fault, then short circuit, then shutdown, then over-temperature. Shutdown during heat shows `mute_o` 1. A short circuit during heat drives `fault_n_o` low. A DC fault with a short circuit survives a shutdown toggle.
- R9: While the synchronised request is low, `sc_pulse_i` is ignored, and the block returns to switching when the request goes high.
- R10: With `fault_n_o` ANDed into the shutdown request, a short circuit produces a low `fault_n_o`, and then a return to all `ch_en_o` 1 with `fault_n_o` 1 within 30 cycles.
- R11: A change of the shutdown request is applied after `SYNC_STAGES`+1 rising edges. After `SYNC_STAGES` edges the outputs are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| shdn_req_n | input | 1 | Shutdown request, active low, asynchronous to clk |
| sc_pulse_i | input | 1 | Short-circuit detect pulse |
| dc_flag_i | input | 1 | DC-offset fault flag |
| ot_hot_i | input | 1 | Die temperature above trip point |
| ot_cool_i | input | 1 | Die temperature below trip point minus hysteresis |
| ch_en_o | output | NUM_CH | Per-channel enable: 1 switching, 0 high impedance |
| mute_o | output | 1 | Mute / low-power idle indication |
| fault_n_o | output | 1 | Fault report, active low |

## Verification
The bench builds the block with three channels, a three-flop synchroniser and a two-cycle clear qualification. The extra channel shows that every enable bit follows the state. The deeper synchroniser makes the latency count in R11 differ from the default. With the two-cycle qualification, a single-cycle low glitch on the shutdown request is too short to clear a short circuit, and a long low does clear it, so both sides of R4 are reached. This case does not exist at the default of one cycle.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
   typedef enum logic [2:0] {
      GS_RESET    = 3'd0,
      GS_ACTIVE   = 3'd1,
      GS_IDLE     = 3'd2,
      GS_SC_HOLD  = 3'd3,
      GS_DC_HOLD  = 3'd4,
      GS_HOT_HOLD = 3'd5
   } guard_state_e;
endpackage

// File: rtl/amp_guard_sync.sv
module amp_guard_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("amp_guard_sync: STAGES must be at least 2");
      end
   endgenerate

   // reset to the shutdown level so the block starts idle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/amp_guard_faults.sv
module amp_guard_faults #(
   parameter int CLR_MIN_LOW = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shdn_sync_i,
   input  logic sc_pulse_i,
   input  logic dc_flag_i,
   input  logic ot_hot_i,
   input  logic ot_cool_i,
   output logic dc_lat_o,
   output logic sc_lat_o,
   output logic therm_o
);
   logic clr_ok;

   generate
      if (CLR_MIN_LOW < 1) begin : g_bad_clr
         $error("amp_guard_faults: CLR_MIN_LOW must be at least 1");
      end
      if (CLR_MIN_LOW == 1) begin : g_clr_direct
         assign clr_ok = !shdn_sync_i;
      end else begin : g_clr_count
         localparam int CW = $clog2(CLR_MIN_LOW + 1);
         localparam logic [CW-1:0] CMAX = CW'(CLR_MIN_LOW);
         logic [CW-1:0] low_cnt, low_inc;
         assign low_inc = (low_cnt == CMAX) ? CMAX : low_cnt + CW'(1);
         assign clr_ok  = !shdn_sync_i && (low_inc == CMAX);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           low_cnt <= '0;
            else if (shdn_sync_i) low_cnt <= '0;
            else                  low_cnt <= low_inc;
         end
      end
   endgenerate

   // DC fault: only the power-on reset releases it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dc_lat_o <= 1'b0;
      else if (dc_flag_i) dc_lat_o <= 1'b1;
   end

   // short circuit: a qualified low request clears; pulses during a low request are ignored
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sc_lat_o <= 1'b0;
      else if (clr_ok)                    sc_lat_o <= 1'b0;
      else if (sc_pulse_i && shdn_sync_i) sc_lat_o <= 1'b1;
   end

   // thermal: set while hot, released only once the cool indication shows
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         therm_o <= 1'b0;
      else if (ot_hot_i)  therm_o <= 1'b1;
      else if (ot_cool_i) therm_o <= 1'b0;
   end
endmodule

// File: rtl/amp_guard_fsm.sv
module amp_guard_fsm
   import amp_guard_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dc_lat_i,
   input  logic         sc_lat_i,
   input  logic         shdn_sync_i,
   input  logic         therm_i,
   output guard_state_e state_o
);
   guard_state_e state_d;

   always_comb begin
      if (dc_lat_i)         state_d = GS_DC_HOLD;
      else if (sc_lat_i)    state_d = GS_SC_HOLD;
      else if (!shdn_sync_i) state_d = GS_IDLE;
      else if (therm_i)     state_d = GS_HOT_HOLD;
      else                  state_d = GS_ACTIVE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= GS_RESET;
      else        state_o <= state_d;
   end
endmodule

// File: rtl/amp_guard_ctrl.sv
module amp_guard_ctrl
   import amp_guard_pkg::*;
#(
   parameter int NUM_CH      = 2,
   parameter int SYNC_STAGES = 2,
   parameter int CLR_MIN_LOW = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shdn_req_n,
   input  logic              sc_pulse_i,
   input  logic              dc_flag_i,
   input  logic              ot_hot_i,
   input  logic              ot_cool_i,
   output logic [NUM_CH-1:0] ch_en_o,
   output logic              mute_o,
   output logic              fault_n_o
);
   logic         shdn_sync;
   logic         dc_lat, sc_lat, therm_q;
   guard_state_e state_q;

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("amp_guard_ctrl: NUM_CH must be at least 1");
      end
   endgenerate

   amp_guard_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (shdn_req_n),
      .q_o   (shdn_sync)
   );

   amp_guard_faults #(.CLR_MIN_LOW(CLR_MIN_LOW)) u_faults (
      .clk         (clk),
      .rst_n       (rst_n),
      .shdn_sync_i (shdn_sync),
      .sc_pulse_i  (sc_pulse_i),
      .dc_flag_i   (dc_flag_i),
      .ot_hot_i    (ot_hot_i),
      .ot_cool_i   (ot_cool_i),
      .dc_lat_o    (dc_lat),
      .sc_lat_o    (sc_lat),
      .therm_o     (therm_q)
   );

   amp_guard_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .dc_lat_i    (dc_lat),
      .sc_lat_i    (sc_lat),
      .shdn_sync_i (shdn_sync),
      .therm_i     (therm_q),
      .state_o     (state_q)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign ch_en_o[c] = (state_q == GS_ACTIVE);
      end
   endgenerate

   assign mute_o    = (state_q == GS_RESET) || (state_q == GS_IDLE);
   assign fault_n_o = !((state_q == GS_SC_HOLD) || (state_q == GS_DC_HOLD));
endmodule

// File: rtl/amp_guard_chk.sv
module amp_guard_chk #(
   parameter int NUM_CH = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dc_flag_i,
   input logic              shdn_sync,
   input logic              dc_lat,
   input logic              sc_lat,
   input logic              therm_q,
   input logic [NUM_CH-1:0] ch_en_o,
   input logic              mute_o,
   input logic              fault_n_o
);
   assert_mute_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mute_o |-> (ch_en_o == '0));

   assert_idle_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !shdn_sync |=> (ch_en_o == '0));

   assert_latched_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dc_lat || sc_lat) |=> (!fault_n_o && ch_en_o == '0));

   assert_sc_clear_needs_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sc_lat) |-> !$past(shdn_sync));

   assert_dc_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dc_lat |=> dc_lat);

   assert_dc_reports_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dc_flag_i |=> ##1 !fault_n_o);

   assert_hot_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      therm_q |=> (ch_en_o == '0));

   assert_no_fault_unlatched_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!dc_lat && !sc_lat) |=> fault_n_o);
endmodule

bind amp_guard_ctrl amp_guard_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .dc_flag_i (dc_flag_i),
   .shdn_sync (shdn_sync),
   .dc_lat    (dc_lat),
   .sc_lat    (sc_lat),
   .therm_q   (therm_q),
   .ch_en_o   (ch_en_o),
   .mute_o    (mute_o),
   .fault_n_o (fault_n_o)
);

// File: tb/amp_guard_ctrl_bench.sv
module amp_guard_ctrl_bench;
   localparam int NCH  = 3;
   localparam int SYNC = 3;
   localparam int CLRN = 2;
   localparam int NV   = 26;

   // row: {shdn, sc, dc, hot, cool, cycles[3:0], en, mute, fault_n}
   localparam logic [11:0] VEC [NV] = '{
      12'b1_0_0_0_1_0110_1_0_1, // 0  R2 running
      12'b0_0_0_0_1_0110_0_1_1, // 1  R2 idle
      12'b1_0_0_0_1_0110_1_0_1, // 2  R2 running
      12'b1_1_0_0_1_0001_1_0_1, // 3  R3 one edge: unchanged
      12'b1_0_0_0_1_0100_0_0_0, // 4  R3 latched
      12'b1_1_0_0_1_0011_0_0_0, // 5  R3 more pulses
      12'b0_0_0_0_1_0001_0_0_0, // 6  R4 one-cycle low
      12'b1_0_0_0_1_1000_0_0_0, // 7  R4 glitch too short
      12'b0_0_0_0_1_1000_0_1_1, // 8  R4 qualified low clears
      12'b0_1_0_0_1_0100_0_1_1, // 9  R9 pulses while low
      12'b1_0_0_0_1_0110_1_0_1, // 10 R9 back to running
      12'b1_0_0_1_0_0100_0_0_1, // 11 R6 R7 hot
      12'b1_0_0_0_0_0110_0_0_1, // 12 R6 not cool yet
      12'b1_0_0_0_1_0100_1_0_1, // 13 R6 resumes
      12'b1_0_0_1_0_0100_0_0_1, // 14 R6 hot again
      12'b0_0_0_1_0_0110_0_1_1, // 15 R8 idle over heat
      12'b1_0_0_1_0_0110_0_0_1, // 16 R7 heat only
      12'b1_1_0_1_0_0001_0_0_1, // 17 R8 pulse during heat
      12'b1_0_0_1_0_0100_0_0_0, // 18 R8 short over heat
      12'b1_0_0_0_1_0110_0_0_0, // 19 R3 still held
      12'b0_0_0_0_1_1000_0_1_1, // 20 R4 cleared
      12'b1_0_0_0_1_0110_1_0_1, // 21 R2 running
      12'b1_0_1_0_1_0001_1_0_1, // 22 R5 one edge: unchanged
      12'b1_0_0_0_1_0100_0_0_0, // 23 R5 latched
      12'b0_0_0_0_1_1000_0_0_0, // 24 R5 R8 survives idle
      12'b1_0_0_0_1_0110_0_0_0  // 25 R5 survives toggle
   };
   localparam int VTAG [NV] = '{2,2,2,3,3,3,4,4,4,9,9,6,6,6,6,8,7,8,8,3,4,2,5,5,5,5};

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           shdn_drv = 1'b0;
   logic           loop_en = 1'b0;
   logic           sc_pulse = 1'b0, dc_flag = 1'b0, ot_hot = 1'b0, ot_cool = 1'b1;
   logic [NCH-1:0] ch_en;
   logic           mute, fault_n;
   logic           shdn_dut;
   int             total = 0, bad = 0;
   logic           saw_fault;

   assign shdn_dut = loop_en ? (shdn_drv & fault_n) : shdn_drv;

   always #5 clk = ~clk;

   amp_guard_ctrl #(.NUM_CH(NCH), .SYNC_STAGES(SYNC), .CLR_MIN_LOW(CLRN)) u_amp_guard_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .shdn_req_n (shdn_dut),
      .sc_pulse_i (sc_pulse),
      .dc_flag_i  (dc_flag),
      .ot_hot_i   (ot_hot),
      .ot_cool_i  (ot_cool),
      .ch_en_o    (ch_en),
      .mute_o     (mute),
      .fault_n_o  (fault_n)
   );

   task automatic check(input string req, input logic [NCH-1:0] e_en,
                        input logic e_mute, input logic e_fn);
      total++;
      if (ch_en !== e_en || mute !== e_mute || fault_n !== e_fn) begin
         bad++;
         $display("FAIL %s: en=%b mute=%b fault_n=%b expected en=%b mute=%b fault_n=%b",
                  req, ch_en, mute, fault_n, e_en, e_mute, e_fn);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      cycles(3);
      check("R1 reset outputs", '0, 1'b1, 1'b1);
      rst_n = 1'b1;
      cycles(10);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1 during power-up and after a reset pulse
      cycles(2);
      check("R1 power-up", '0, 1'b1, 1'b1);
      shdn_drv = 1'b1;
      do_reset();
      check("R2 running after reset", '1, 1'b0, 1'b1);

      // R11 exact synchroniser latency
      shdn_drv = 1'b0;
      cycles(SYNC);
      check("R11 before latency", '1, 1'b0, 1'b1);
      cycles(1);
      check("R11 at latency", '0, 1'b1, 1'b1);
      shdn_drv = 1'b1;
      cycles(8);

      for (int i = 0; i < NV; i++) begin
         logic [11:0] v;
         v = VEC[i];
         shdn_drv = v[11];
         sc_pulse = v[10];
         dc_flag  = v[9];
         ot_hot   = v[8];
         ot_cool  = v[7];
         cycles(int'(v[6:3]));
         check($sformatf("R%0d table row %0d", VTAG[i], i), {NCH{v[2]}}, v[1], v[0]);
      end
      sc_pulse = 1'b0; dc_flag = 1'b0; ot_hot = 1'b0; ot_cool = 1'b1; shdn_drv = 1'b1;

      // R5: power-on reset is the only release for a DC fault
      do_reset();
      check("R5 reset clears DC fault", '1, 1'b0, 1'b1);

      // R8: DC and short together outlive a shutdown toggle
      sc_pulse = 1'b1; dc_flag = 1'b1;
      cycles(1);
      sc_pulse = 1'b0; dc_flag = 1'b0;
      cycles(4);
      check("R8 dual fault", '0, 1'b0, 1'b0);
      shdn_drv = 1'b0;
      cycles(10);
      check("R8 dual fault during idle", '0, 1'b0, 1'b0);
      shdn_drv = 1'b1;
      cycles(8);
      check("R8 dual fault after toggle", '0, 1'b0, 1'b0);

      // R10: fault line looped into the request
      do_reset();
      loop_en = 1'b1;
      saw_fault = 1'b0;
      sc_pulse = 1'b1;
      cycles(1);
      sc_pulse = 1'b0;
      for (int k = 0; k < 30; k++) begin
         cycles(1);
         if (!fault_n) saw_fault = 1'b1;
      end
      total++;
      if (!saw_fault) begin
         bad++;
         $display("FAIL R10 fault seen: actual=0 expected=1");
      end
      check("R10 recovered", '1, 1'b0, 1'b1);
      loop_en = 1'b0;

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule